// File: doc/BRIEF.md
# Write-Protected Pin Function Controller

This block is a register bank that sets up pin multiplexing and pad controls for a group of I/O pins. The pins are arranged in banks of 32. A simple single-cycle register bus writes and reads the settings. Each pin has four kinds of setting: whether it is routed to a peripheral or left as GPIO, a 4-bit peripheral function code, a drive-strength code, and a pull-up/pull-down configuration. The block drives all of these continuously on per-pin output vectors. The drive setting is presented as a current in milliamps.

The peripheral select, function and drive words are guarded. A write to one of them lands only when the bus write just before it went to the protection word and carried the bitwise inverse of the new data. Any other write in between disarms the unlock. A guarded write that is refused is dropped and sets a sticky error bit, which software can read and clear. Reads never disturb the unlock. The pull words need no unlock.

With the default parameters there are 2 banks (64 pins). Bank 0 uses 3-bit drive fields and bank 1 uses 2-bit drive fields.

Top module: `pinfunc_ctrl`

## Requirements
- R1: After reset every stored word is zero. Every pin is GPIO with function 0 and no pull. Drive is at the lowest code: 3 mA on 3-bit pins and 6 mA on 2-bit pins. The error bit is 0.
- R2: A write to a guarded word (select, function, drive) takes effect only if the immediately preceding bus write was to offset 0x000 and held the bitwise inverse of the new data.
- R3: A refused guarded write leaves the word unchanged and sets bit 0 of offset 0x004. That bit stays set until a write to 0x004 with bit 0 = 1 clears it.
- R4: Any bus write other than to 0x000 disarms a pending unlock, including writes to pull words and to 0x004. A protection value that is not the inverse of the next data does not unlock. Idle cycles and reads keep the unlock armed.
- R5: The select word at 0x100 + 4·b maps bit i to pin 32·b + i. A value of 1 routes the pin to a peripheral and 0 leaves it as GPIO.
- R6: The function word at 0x200 + 4·k holds 4-bit field j in bits [4j+3:4j], which is the code for pin 8·k + j.
- R7: Drive words 0–3 at 0x300–0x30C hold 3-bit fields. Field j is in bits [3j+2:3j] and belongs to pin 8·k + j; its current is (code+1)·3 mA, and bits 31:24 read 0. Drive words 4–5 at 0x310–0x314 hold 2-bit fields. Field j is in bits [2j+1:2j] and belongs to pin 32 + 16·(k−4) + j; its current is (code+1)·6 mA.
- R8: Pull-enable words are at 0x400 + 4·b and pull-direction words at 0x440 + 4·b. Both are written directly with no unlock. A pin pulls up when enable = 1 and direction = 1. It pulls down when enable = 1 and direction = 0.
- R9: rdata_o updates on the clock edge that samples re_i and holds the current contents of the register. Offset 0x000 and unmapped offsets read 0.
- R10: Per-pin outputs change on the clock edge that samples an accepted write, not before.
- R11: A read and a write to the same word in the same cycle return the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 12 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| we_i | input | 1 | Write strobe, single cycle |
| re_i | input | 1 | Read strobe, single cycle |
| rdata_o | output | 32 | Read data, registered |
| periph_sel_o | output | 64 | Per pin: 1 = peripheral, 0 = GPIO |
| func_o | output | 256 | Per pin 4-bit function code, pin p at [4p+3:4p] |
| drive_ma_o | output | 320 | Per pin drive current in mA, pin p at [5p+4:5p] |
| pull_up_o | output | 64 | Per pin pull-up active |
| pull_dn_o | output | 64 | Per pin pull-down active |

## Verification
Two functions can land in the same cycle. The first case is a read and a write to the same word in one cycle: the bench asserts both strobes on a pull word and expects the old contents on rdata_o, then reads again and expects the new value. The second case is a read that falls between an unlock and its guarded write. The bench puts a read in that slot and then expects the guarded write to land, which shows that the read neither cancelled the unlock nor changed any stored state.

// File: rtl/pinfunc_pkg.sv
package pinfunc_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned ADDR_W   = 12;
  localparam int unsigned FUNC_W   = 4;
  localparam int unsigned MA_W     = 5;
  localparam int unsigned IDX_W    = 8;

  // word addresses (byte offset >> 2)
  localparam logic [9:0] WA_PROT = 10'h000;
  localparam logic [9:0] WA_ERR  = 10'h001;
  localparam logic [9:0] WA_SEL  = 10'h040;
  localparam logic [9:0] WA_FUNC = 10'h080;
  localparam logic [9:0] WA_DRV  = 10'h0C0;
  localparam logic [9:0] WA_PEN  = 10'h100;
  localparam logic [9:0] WA_PDIR = 10'h110;

  typedef enum logic [2:0] {
    RG_NONE, RG_PROT, RG_ERR, RG_SEL, RG_FUNC, RG_DRV, RG_PEN, RG_PDIR
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e         kind;
    logic [IDX_W-1:0]  idx;
  } reg_hit_t;

  function automatic logic is_guarded(reg_kind_e k);
    return (k == RG_SEL) || (k == RG_FUNC) || (k == RG_DRV);
  endfunction
endpackage

// File: rtl/pinfunc_decode.sv
module pinfunc_decode
  import pinfunc_pkg::*;
#(
  parameter int unsigned N_BANK = 2,
  parameter int unsigned N_FUNC = 8,
  parameter int unsigned N_DRV  = 6
) (
  input  logic [ADDR_W-1:0] addr_i,
  output reg_hit_t          hit_o
);
  localparam logic [9:0] SEL_END  = WA_SEL  + 10'(N_BANK);
  localparam logic [9:0] FUNC_END = WA_FUNC + 10'(N_FUNC);
  localparam logic [9:0] DRV_END  = WA_DRV  + 10'(N_DRV);
  localparam logic [9:0] PEN_END  = WA_PEN  + 10'(N_BANK);
  localparam logic [9:0] PDIR_END = WA_PDIR + 10'(N_BANK);

  logic [9:0] wa;
  logic [9:0] off;

  assign wa = addr_i[ADDR_W-1:2];

  always_comb begin
    hit_o.kind = RG_NONE;
    off        = '0;
    if (wa == WA_PROT) begin
      hit_o.kind = RG_PROT;
    end else if (wa == WA_ERR) begin
      hit_o.kind = RG_ERR;
    end else if (wa >= WA_SEL && wa < SEL_END) begin
      hit_o.kind = RG_SEL;
      off        = wa - WA_SEL;
    end else if (wa >= WA_FUNC && wa < FUNC_END) begin
      hit_o.kind = RG_FUNC;
      off        = wa - WA_FUNC;
    end else if (wa >= WA_DRV && wa < DRV_END) begin
      hit_o.kind = RG_DRV;
      off        = wa - WA_DRV;
    end else if (wa >= WA_PEN && wa < PEN_END) begin
      hit_o.kind = RG_PEN;
      off        = wa - WA_PEN;
    end else if (wa >= WA_PDIR && wa < PDIR_END) begin
      hit_o.kind = RG_PDIR;
      off        = wa - WA_PDIR;
    end
    hit_o.idx = off[IDX_W-1:0];
  end
endmodule

// File: rtl/pinfunc_guard.sv
module pinfunc_guard
  import pinfunc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  reg_kind_e         kind_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              wr_ok_o,
  output logic              err_o
);
  logic              armed_q;
  logic [DATA_W-1:0] key_q;
  logic              err_q;
  logic              guarded_wr;
  logic              err_clr;

  assign guarded_wr = we_i && is_guarded(kind_i);
  assign wr_ok_o    = guarded_wr && armed_q && (wdata_i == ~key_q);
  assign err_clr    = we_i && (kind_i == RG_ERR) && wdata_i[0];
  assign err_o      = err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      key_q   <= '0;
    end else if (we_i) begin
      // every write re-evaluates the unlock; only a protection write arms it
      armed_q <= (kind_i == RG_PROT);
      if (kind_i == RG_PROT) key_q <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     err_q <= 1'b0;
    else if (guarded_wr && !wr_ok_o) err_q <= 1'b1;
    else if (err_clr)                err_q <= 1'b0;
  end

  p_cancel_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && kind_i != RG_PROT) |=> !armed_q);

  p_read_keeps_arm_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(armed_q));

  p_err_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q && !err_clr) |=> err_q);

  p_reject_flags_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (guarded_wr && !armed_q) |=> err_q);
endmodule

// File: rtl/pinfunc_regs.sv
module pinfunc_regs
  import pinfunc_pkg::*;
#(
  parameter int unsigned N_BANK = 2,
  parameter int unsigned N_FUNC = 8,
  parameter int unsigned N_DRV  = 6,
  parameter int unsigned N_DRV3 = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic                       re_i,
  input  reg_hit_t                   hit_i,
  input  logic [DATA_W-1:0]          wdata_i,
  input  logic                       wr_ok_i,
  input  logic                       err_i,
  output logic [DATA_W-1:0]          rdata_o,
  output logic [N_BANK*DATA_W-1:0]   sel_o,
  output logic [N_FUNC*DATA_W-1:0]   func_o,
  output logic [N_DRV*DATA_W-1:0]    drv_o,
  output logic [N_BANK*DATA_W-1:0]   pen_o,
  output logic [N_BANK*DATA_W-1:0]   pdir_o
);
  localparam int unsigned BW = (N_BANK > 1) ? $clog2(N_BANK) : 1;
  localparam int unsigned FW = (N_FUNC > 1) ? $clog2(N_FUNC) : 1;
  localparam int unsigned DW = (N_DRV  > 1) ? $clog2(N_DRV)  : 1;
  localparam logic [DATA_W-1:0] MASK3 = 32'h00FF_FFFF;
  localparam logic [DATA_W-1:0] MASK2 = 32'hFFFF_FFFF;

  logic [DATA_W-1:0] sel_q  [N_BANK];
  logic [DATA_W-1:0] func_q [N_FUNC];
  logic [DATA_W-1:0] drv_q  [N_DRV];
  logic [DATA_W-1:0] pen_q  [N_BANK];
  logic [DATA_W-1:0] pdir_q [N_BANK];
  logic [DATA_W-1:0] rd_mux;
  logic [BW-1:0]     bi;
  logic [FW-1:0]     fi;
  logic [DW-1:0]     di;

  assign bi = hit_i.idx[BW-1:0];
  assign fi = hit_i.idx[FW-1:0];
  assign di = hit_i.idx[DW-1:0];

  function automatic logic [DATA_W-1:0] drv_mask(logic [DW-1:0] k);
    return (32'(k) < N_DRV3) ? MASK3 : MASK2;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_BANK; i++) begin
        sel_q[i]  <= '0;
        pen_q[i]  <= '0;
        pdir_q[i] <= '0;
      end
      for (int i = 0; i < N_FUNC; i++) func_q[i] <= '0;
      for (int i = 0; i < N_DRV;  i++) drv_q[i]  <= '0;
    end else if (we_i) begin
      unique case (hit_i.kind)
        RG_SEL:  if (wr_ok_i) sel_q[bi]  <= wdata_i;
        RG_FUNC: if (wr_ok_i) func_q[fi] <= wdata_i;
        RG_DRV:  if (wr_ok_i) drv_q[di]  <= wdata_i & drv_mask(di);
        RG_PEN:  pen_q[bi]  <= wdata_i;
        RG_PDIR: pdir_q[bi] <= wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (hit_i.kind)
      RG_ERR:  rd_mux = {{(DATA_W-1){1'b0}}, err_i};
      RG_SEL:  rd_mux = sel_q[bi];
      RG_FUNC: rd_mux = func_q[fi];
      RG_DRV:  rd_mux = drv_q[di];
      RG_PEN:  rd_mux = pen_q[bi];
      RG_PDIR: rd_mux = pdir_q[bi];
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= rd_mux;
  end

  for (genvar b = 0; b < N_BANK; b++) begin : g_bank
    assign sel_o [b*DATA_W +: DATA_W] = sel_q[b];
    assign pen_o [b*DATA_W +: DATA_W] = pen_q[b];
    assign pdir_o[b*DATA_W +: DATA_W] = pdir_q[b];
  end
  for (genvar k = 0; k < N_FUNC; k++) begin : g_func
    assign func_o[k*DATA_W +: DATA_W] = func_q[k];
  end
  for (genvar k = 0; k < N_DRV; k++) begin : g_drv
    assign drv_o[k*DATA_W +: DATA_W] = drv_q[k];
  end

  p_sel_guarded_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_o != $past(sel_o)) |-> $past(wr_ok_i));

  p_func_guarded_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (func_o != $past(func_o)) |-> $past(wr_ok_i));

  p_pull_free_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && hit_i.kind == RG_PEN && hit_i.idx == '0) |=> pen_q[0] == $past(wdata_i));

  p_unmapped_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && (hit_i.kind == RG_NONE || hit_i.kind == RG_PROT)) |=> rdata_o == '0);
endmodule

// File: rtl/pinfunc_pinout.sv
module pinfunc_pinout
  import pinfunc_pkg::*;
#(
  parameter int unsigned N_BANK  = 2,
  parameter int unsigned N_FUNC  = 8,
  parameter int unsigned N_DRV   = 6,
  parameter int unsigned N_DRV3B = 1,
  parameter int unsigned FULL_MA = 24
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [N_BANK*DATA_W-1:0]   sel_i,
  input  logic [N_FUNC*DATA_W-1:0]   func_i,
  input  logic [N_DRV*DATA_W-1:0]    drv_i,
  input  logic [N_BANK*DATA_W-1:0]   pen_i,
  input  logic [N_BANK*DATA_W-1:0]   pdir_i,
  output logic [N_BANK*32-1:0]       periph_sel_o,
  output logic [N_BANK*32*FUNC_W-1:0] func_o,
  output logic [N_BANK*32*MA_W-1:0]  drive_ma_o,
  output logic [N_BANK*32-1:0]       pull_up_o,
  output logic [N_BANK*32-1:0]       pull_dn_o
);
  localparam int unsigned N_PIN  = N_BANK * 32;
  localparam int unsigned P3_END = N_DRV3B * 32;
  localparam int unsigned W3_CNT = N_DRV3B * 4;
  localparam int unsigned STEP3  = FULL_MA / 8;
  localparam int unsigned STEP2  = FULL_MA / 4;

  // select and function fields line up one-to-one with pin order
  assign periph_sel_o = sel_i;
  assign func_o       = func_i[N_PIN*FUNC_W-1:0];
  assign pull_up_o    = pen_i & pdir_i;
  assign pull_dn_o    = pen_i & ~pdir_i;

  for (genvar p = 0; p < N_PIN; p++) begin : g_pin
    logic [MA_W-1:0] ma;
    if (p < P3_END) begin : g_w3
      localparam int unsigned LSB = (p / 8) * DATA_W + (p % 8) * 3;
      logic [2:0] code;
      assign code = drv_i[LSB +: 3];
      assign ma   = MA_W'((32'(code) + 1) * STEP3);
    end else begin : g_w2
      localparam int unsigned Q   = p - P3_END;
      localparam int unsigned LSB = (W3_CNT + Q / 16) * DATA_W + (Q % 16) * 2;
      logic [1:0] code;
      assign code = drv_i[LSB +: 2];
      assign ma   = MA_W'((32'(code) + 1) * STEP2);
    end
    assign drive_ma_o[p*MA_W +: MA_W] = ma;

    p_drive_range_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ma != '0) && (32'(ma) <= FULL_MA));
  end
endmodule

// File: rtl/pinfunc_ctrl.sv
module pinfunc_ctrl
  import pinfunc_pkg::*;
#(
  parameter int unsigned N_BANK  = 2,
  parameter int unsigned N_DRV3B = 1,
  parameter int unsigned FULL_MA = 24
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [DATA_W-1:0]            wdata_i,
  input  logic                         we_i,
  input  logic                         re_i,
  output logic [DATA_W-1:0]            rdata_o,
  output logic [N_BANK*32-1:0]         periph_sel_o,
  output logic [N_BANK*32*FUNC_W-1:0]  func_o,
  output logic [N_BANK*32*MA_W-1:0]    drive_ma_o,
  output logic [N_BANK*32-1:0]         pull_up_o,
  output logic [N_BANK*32-1:0]         pull_dn_o
);
  localparam int unsigned N_FUNC = N_BANK * 32 * FUNC_W / DATA_W;
  localparam int unsigned N_DRV3 = N_DRV3B * 4;
  localparam int unsigned N_DRV  = N_DRV3 + (N_BANK - N_DRV3B) * 2;

  reg_hit_t                 hit;
  logic                     wr_ok;
  logic                     err;
  logic [N_BANK*DATA_W-1:0] sel_w, pen_w, pdir_w;
  logic [N_FUNC*DATA_W-1:0] func_w;
  logic [N_DRV*DATA_W-1:0]  drv_w;

  pinfunc_decode #(.N_BANK(N_BANK), .N_FUNC(N_FUNC), .N_DRV(N_DRV)) u_decode (
    .addr_i (addr_i),
    .hit_o  (hit)
  );

  pinfunc_guard u_guard (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we_i),
    .kind_i  (hit.kind),
    .wdata_i (wdata_i),
    .wr_ok_o (wr_ok),
    .err_o   (err)
  );

  pinfunc_regs #(
    .N_BANK(N_BANK), .N_FUNC(N_FUNC), .N_DRV(N_DRV), .N_DRV3(N_DRV3)
  ) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we_i),
    .re_i    (re_i),
    .hit_i   (hit),
    .wdata_i (wdata_i),
    .wr_ok_i (wr_ok),
    .err_i   (err),
    .rdata_o (rdata_o),
    .sel_o   (sel_w),
    .func_o  (func_w),
    .drv_o   (drv_w),
    .pen_o   (pen_w),
    .pdir_o  (pdir_w)
  );

  pinfunc_pinout #(
    .N_BANK(N_BANK), .N_FUNC(N_FUNC), .N_DRV(N_DRV),
    .N_DRV3B(N_DRV3B), .FULL_MA(FULL_MA)
  ) u_pinout (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sel_i        (sel_w),
    .func_i       (func_w),
    .drv_i        (drv_w),
    .pen_i        (pen_w),
    .pdir_i       (pdir_w),
    .periph_sel_o (periph_sel_o),
    .func_o       (func_o),
    .drive_ma_o   (drive_ma_o),
    .pull_up_o    (pull_up_o),
    .pull_dn_o    (pull_dn_o)
  );
endmodule

// File: tb/pinfunc_ctrl_tb.sv
module pinfunc_ctrl_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [11:0]  addr = '0;
  logic [31:0]  wdata = '0;
  logic         we = 1'b0;
  logic         re = 1'b0;
  logic [31:0]  rdata;
  logic [63:0]  psel, pup, pdn;
  logic [255:0] func;
  logic [319:0] dma;
  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;  // 50 MHz

  pinfunc_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
    .we_i(we), .re_i(re), .rdata_o(rdata), .periph_sel_o(psel),
    .func_o(func), .drive_ma_o(dma), .pull_up_o(pup), .pull_dn_o(pdn)
  );

  typedef struct packed {
    logic        rd;
    logic [3:0]  req;
    logic [11:0] addr;
    logic [31:0] data;
  } vec_t;

  localparam int NV = 33;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 4'd1, 12'h100, 32'h0},             // R1 reset value
    '{1'b0, 4'd0, 12'h000, ~32'hA5A5_0003},
    '{1'b0, 4'd0, 12'h100, 32'hA5A5_0003},
    '{1'b1, 4'd5, 12'h100, 32'hA5A5_0003},     // R5 / R2 accepted
    '{1'b0, 4'd0, 12'h104, 32'h1},             // no unlock
    '{1'b1, 4'd3, 12'h104, 32'h0},             // R3 dropped
    '{1'b1, 4'd3, 12'h004, 32'h1},             // R3 flag set
    '{1'b0, 4'd0, 12'h004, 32'h1},
    '{1'b1, 4'd3, 12'h004, 32'h0},             // R3 cleared
    '{1'b0, 4'd0, 12'h000, ~32'h7654_3210},
    '{1'b0, 4'd0, 12'h400, 32'hF},             // cancels unlock
    '{1'b0, 4'd0, 12'h200, 32'h7654_3210},
    '{1'b1, 4'd4, 12'h200, 32'h0},             // R4 cancelled
    '{1'b1, 4'd8, 12'h400, 32'hF},             // R8 no unlock needed
    '{1'b0, 4'd0, 12'h000, 32'h1234_5678},
    '{1'b0, 4'd0, 12'h200, 32'h1},
    '{1'b1, 4'd4, 12'h200, 32'h0},             // R4 mismatch
    '{1'b0, 4'd0, 12'h000, ~32'h7654_3210},
    '{1'b1, 4'd4, 12'h100, 32'hA5A5_0003},     // R4 read between
    '{1'b0, 4'd0, 12'h200, 32'h7654_3210},
    '{1'b1, 4'd6, 12'h200, 32'h7654_3210},     // R6
    '{1'b0, 4'd0, 12'h000, 32'h0},
    '{1'b0, 4'd0, 12'h300, 32'hFFFF_FFFF},
    '{1'b1, 4'd7, 12'h300, 32'h00FF_FFFF},     // R7 mask
    '{1'b0, 4'd0, 12'h000, ~32'h0000_001B},
    '{1'b0, 4'd0, 12'h310, 32'h0000_001B},
    '{1'b1, 4'd7, 12'h310, 32'h0000_001B},     // R7 2-bit word
    '{1'b0, 4'd0, 12'h440, 32'h5},
    '{1'b1, 4'd8, 12'h440, 32'h5},             // R8
    '{1'b1, 4'd9, 12'h0FC, 32'h0},             // R9 unmapped
    '{1'b1, 4'd9, 12'h000, 32'h0},             // R9 protection word
    '{1'b1, 4'd9, 12'h108, 32'h0},             // R9 past last bank
    '{1'b1, 4'd3, 12'h004, 32'h1}              // R3 set again
  };

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic bus_rd(logic [11:0] a);
    @(negedge clk);
    addr = a; re = 1'b1;
    @(negedge clk);
    re = 1'b0;
  endtask

  function automatic logic [31:0] ma(int p);
    return 32'(dma[p*5 +: 5]);
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 sel",   32'(psel != 0), 32'd0);
    chk("R1 func",  32'(func != 0), 32'd0);
    chk("R1 pull",  32'(pup | pdn) , 32'd0);
    chk("R1 drv3",  ma(0),  32'd3);
    chk("R1 drv2",  ma(40), 32'd6);
    chk("R1 rdata", rdata,  32'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].rd) begin
        bus_rd(VEC[i].addr);
        chk($sformatf("R%0d vec%0d", VEC[i].req, i), rdata, VEC[i].data);
      end else begin
        bus_wr(VEC[i].addr, VEC[i].data);
      end
    end

    // pin view of the table's writes
    chk("R5 psel bank0", psel[31:0], 32'hA5A5_0003);
    chk("R5 psel bank1", psel[63:32], 32'h0);
    chk("R6 func pin5", 32'(func[4*5 +: 4]), 32'd5);
    chk("R6 func pin7", 32'(func[4*7 +: 4]), 32'd7);
    chk("R7 pin0",  ma(0),  32'd24);
    chk("R7 pin7",  ma(7),  32'd24);
    chk("R7 pin8",  ma(8),  32'd3);
    chk("R7 pin32", ma(32), 32'd24);
    chk("R7 pin33", ma(33), 32'd18);
    chk("R7 pin34", ma(34), 32'd12);
    chk("R7 pin35", ma(35), 32'd6);
    chk("R8 up",   32'(pup[4:0]), 32'b00101);
    chk("R8 down", 32'(pdn[4:0]), 32'b01010);

    // R10 output timing
    bus_wr(12'h000, ~32'h1);
    @(negedge clk);
    addr = 12'h104; wdata = 32'h1; we = 1'b1;
    #1 chk("R10 before edge", 32'(psel[32]), 32'd0);
    @(negedge clk);
    we = 1'b0;
    chk("R10 after edge", 32'(psel[32]), 32'd1);

    // R11 read and write together
    @(negedge clk);
    addr = 12'h400; wdata = 32'h0; we = 1'b1; re = 1'b1;
    @(negedge clk);
    we = 1'b0; re = 1'b0;
    chk("R11 old value", rdata, 32'hF);
    chk("R11 pins updated", 32'(pup[0]), 32'd0);
    bus_rd(12'h400);
    chk("R11 new value", rdata, 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule